// File: doc/BRIEF.md
# Command-Decoded Clock Register and Scratch RAM Access Controller

This block sits behind a byte-level serial front end and owns a small real-time-clock register set (seven timekeeping registers and one control register), a read-only status byte and a 96-byte scratch RAM. The front end hands it bytes with a valid strobe, raises an end strobe when the bus transaction closes, and pulses a read request whenever it needs the next byte to send. The first byte of each transaction is a command. The command selects a single register, a single RAM byte, the status byte, or one of two burst modes. A clock burst moves all eight clock registers. A RAM burst walks the scratch RAM from its first byte.

Writes are guarded by a protect flag held in the control register. A clock burst write is staged and committed atomically when its eighth byte arrives. A RAM burst write stores each byte as soon as it arrives. Read data is registered: the front end sees the requested byte one clock after it asks. Bus framing and the timekeeping counters are outside this block.

Top module: `rtc_cmd_access`

## Requirements
- R1: After reset or an end strobe, the next valid byte is taken as a command, and the following valid bytes are data for that command. A read request with no command open returns 00h.
- R2: Commands 02h+2i write clock register i and 03h+2i read it, for i = 0..7, where registers 0..6 are timekeeping and register 7 is control. A single write stores only the first data byte of the transaction.
- R3: While bit 7 of the control register is 1, writes to timekeeping registers and to RAM are dropped. The control register itself can still be written with command 10h.
- R4: Command 00h opens a clock burst write. The data bytes go to registers 0..6 and then to control, and all eight are updated together on the eighth byte. If the transaction ends earlier, no register changes.
- R5: If protect is 1 when a clock burst write command arrives, none of the eight registers changes, control included.
- R6: Command 01h opens a clock burst read. Successive read requests return registers 0..6, then control, then 00h for every later request.
- R7: An even command from 3Eh to FCh writes RAM byte (cmd-3Eh)>>1. An odd command from 3Fh to FDh reads RAM byte (cmd-3Fh)>>1.
- R8: Command FEh opens a RAM burst write starting at byte 0. Each data byte is stored as it arrives, so a short burst keeps what it delivered. Bytes beyond byte 95 are dropped.
- R9: Command FFh opens a RAM burst read from byte 0. The 96 RAM bytes are returned in order, and then 00h for every later request.
- R10: Command 13h reads the status byte {crystal fail, data valid, battery low, alarm, 4'b0000}, bit 7 down to bit 0. Bits 3..0 are always 0.
- R11: Any other command (for example 12h or 14h..3Dh) writes nothing and reads 00h.
- R12: rd_data takes its new value at the clock edge that samples rd_req, and it holds between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A received byte is on byte_data this cycle |
| byte_data | input | 8 | Received byte (command or data) |
| xfer_end | input | 1 | The bus transaction has closed |
| rd_req | input | 1 | Front end requests the next byte to transmit |
| xtal_fail_i | input | 1 | Crystal-fail flag for the status byte |
| data_valid_i | input | 1 | Data-valid flag for the status byte |
| batt_low_i | input | 1 | Battery-low flag for the status byte |
| alarm_i | input | 1 | Alarm-output flag for the status byte |
| rd_data | output | 8 | Byte to transmit, updated one clock after rd_req |

## Verification
Writes land at the clock edge that samples byte_valid. Their effect is observed only later, through a read command in a new transaction, so no write check depends on the exact cycle. A read result is due one clock after the cycle in which rd_req is high. The bench raises its strobes on the falling edge, drops them on the next falling edge, and samples rd_data there, which is half a period after the edge that loaded it. Burst reads are checked one request at a time, and each expected value comes from the bench's own model of register and RAM contents.

// File: rtl/rtc_access_pkg.sv
package rtc_access_pkg;

  localparam logic [7:0] CMD_CBURST_WR = 8'h00;
  localparam logic [7:0] CMD_CBURST_RD = 8'h01;
  localparam logic [7:0] CMD_REG_BASE  = 8'h02;
  localparam logic [7:0] CMD_STATUS_RD = 8'h13;
  localparam logic [7:0] CMD_RAM_BASE  = 8'h3E;
  localparam logic [7:0] CMD_RBURST_WR = 8'hFE;
  localparam logic [7:0] CMD_RBURST_RD = 8'hFF;
  localparam int         WP_BIT        = 7;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_REG_WR,
    OP_REG_RD,
    OP_STAT_RD,
    OP_CBURST_WR,
    OP_CBURST_RD,
    OP_RAM_WR,
    OP_RAM_RD,
    OP_RBURST_WR,
    OP_RBURST_RD
  } op_t;

  // Slot addressed by a paired write/read command within a range.
  function automatic logic [7:0] slot_of(input logic [7:0] cmd, input logic [7:0] base);
    return (cmd - base) >> 1;
  endfunction

  function automatic logic [7:0] status_byte(input logic xf, input logic dv,
                                             input logic bl, input logic al);
    return {xf, dv, bl, al, 4'b0000};
  endfunction

endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_access_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int RAM_DEPTH = 96,
  parameter int IDX_W     = 7
) (
  input  logic [7:0]       cmd,
  output op_t              op,
  output logic [IDX_W-1:0] idx
);
  localparam int REG_LAST = int'(CMD_REG_BASE) + 2 * CLK_REGS - 1;
  localparam int RAM_LAST = int'(CMD_RAM_BASE) + 2 * RAM_DEPTH - 1;

  always_comb begin
    op  = OP_NONE;
    idx = '0;
    if (cmd == CMD_CBURST_WR) begin
      op = OP_CBURST_WR;
    end else if (cmd == CMD_CBURST_RD) begin
      op = OP_CBURST_RD;
    end else if (cmd == CMD_STATUS_RD) begin
      op = OP_STAT_RD;
    end else if (cmd == CMD_RBURST_WR) begin
      op = OP_RBURST_WR;
    end else if (cmd == CMD_RBURST_RD) begin
      op = OP_RBURST_RD;
    end else if (int'(cmd) >= int'(CMD_REG_BASE) && int'(cmd) <= REG_LAST) begin
      op  = cmd[0] ? OP_REG_RD : OP_REG_WR;
      idx = IDX_W'(slot_of(cmd, CMD_REG_BASE));
    end else if (int'(cmd) >= int'(CMD_RAM_BASE) && int'(cmd) <= RAM_LAST) begin
      op  = cmd[0] ? OP_RAM_RD : OP_RAM_WR;
      idx = IDX_W'(slot_of(cmd, CMD_RAM_BASE));
    end
  end

endmodule

// File: rtl/rtc_clock_bank.sv
module rtc_clock_bank #(
  parameter int CLK_REGS = 8,
  parameter int CIDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CIDX_W-1:0]        wr_idx,
  input  logic [7:0]               wr_data,
  input  logic                     stg_en,
  input  logic [CIDX_W-1:0]        stg_idx,
  input  logic [7:0]               stg_data,
  input  logic                     commit,
  output logic [CLK_REGS-1:0][7:0] regs
);
  localparam int STG_N = CLK_REGS - 1;

  logic [7:0] stage [STG_N];

  // Staging slots for all but the last burst byte, which commits directly.
  for (genvar g = 0; g < STG_N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage[g] <= '0;
      end else if (stg_en && stg_idx == CIDX_W'(g)) begin
        stage[g] <= stg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (commit) begin
      for (int i = 0; i < STG_N; i++) begin
        regs[i] <= stage[i];
      end
      regs[CLK_REGS-1] <= stg_data;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en && int'(wr_addr) < DEPTH) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/rtc_cmd_access.sv
module rtc_cmd_access
  import rtc_access_pkg::*;
#(
  parameter int NUM_TIME_REGS = 7,
  parameter int RAM_DEPTH     = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       xfer_end,
  input  logic       rd_req,
  input  logic       xtal_fail_i,
  input  logic       data_valid_i,
  input  logic       batt_low_i,
  input  logic       alarm_i,
  output logic [7:0] rd_data
);
  localparam int CLK_REGS = NUM_TIME_REGS + 1;
  localparam int CTRL_IDX = NUM_TIME_REGS;
  localparam int CIDX_W   = $clog2(CLK_REGS);
  localparam int IDX_W    = $clog2(RAM_DEPTH);
  localparam int PTR_W    = $clog2(RAM_DEPTH + 1);

  // Transaction state
  logic             active_q;
  op_t              op_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] ptr_q;
  logic             wp_lat_q;

  // Decoder outputs
  op_t              dec_op;
  logic [IDX_W-1:0] dec_idx;

  // Named events
  logic cmd_accept, data_byte, wp_now;
  logic reg_wr_fire, stg_en, burst_commit, ram_wr_fire;
  logic ptr_step, is_wr_op, is_burst_rd, rd_is_status;
  logic [PTR_W-1:0] ptr_lim;

  logic [CLK_REGS-1:0][7:0]       clk_regs;
  logic [8*NUM_TIME_REGS-1:0]     time_regs_flat;
  logic [IDX_W-1:0]               ram_wr_addr, ram_rd_addr;
  logic [7:0]                     ram_rd_byte, rd_next;

  rtc_cmd_decode #(
    .CLK_REGS (CLK_REGS),
    .RAM_DEPTH(RAM_DEPTH),
    .IDX_W    (IDX_W)
  ) u_decode (
    .cmd(byte_data),
    .op (dec_op),
    .idx(dec_idx)
  );

  assign cmd_accept     = byte_valid && !active_q && !xfer_end;
  assign data_byte      = byte_valid && active_q && !xfer_end;
  assign wp_now         = clk_regs[CTRL_IDX][WP_BIT];
  assign time_regs_flat = clk_regs[CTRL_IDX-1:0];
  assign rd_is_status   = active_q && op_q == OP_STAT_RD;

  assign is_wr_op    = op_q inside {OP_REG_WR, OP_RAM_WR, OP_CBURST_WR, OP_RBURST_WR};
  assign is_burst_rd = op_q inside {OP_CBURST_RD, OP_RBURST_RD};

  always_comb begin
    case (op_q)
      OP_REG_WR, OP_RAM_WR:       ptr_lim = PTR_W'(1);
      OP_CBURST_WR, OP_CBURST_RD: ptr_lim = PTR_W'(CLK_REGS);
      OP_RBURST_WR, OP_RBURST_RD: ptr_lim = PTR_W'(RAM_DEPTH);
      default:                    ptr_lim = '0;
    endcase
  end

  assign ptr_step = ((data_byte && is_wr_op) || (rd_req && active_q && is_burst_rd))
                    && (ptr_q < ptr_lim);

  // Single register write: first data byte only, control always reachable
  assign reg_wr_fire = data_byte && op_q == OP_REG_WR && ptr_q == '0
                       && (!wp_now || int'(idx_q) == CTRL_IDX);

  // Clock burst: stage bytes 0..CTRL_IDX-1, commit on the last one
  assign stg_en       = data_byte && op_q == OP_CBURST_WR && int'(ptr_q) < CTRL_IDX;
  assign burst_commit = data_byte && op_q == OP_CBURST_WR && int'(ptr_q) == CTRL_IDX
                        && !wp_lat_q;

  // RAM writes, single and burst
  assign ram_wr_fire = data_byte && !wp_now &&
                       ((op_q == OP_RAM_WR && ptr_q == '0) ||
                        (op_q == OP_RBURST_WR && int'(ptr_q) < RAM_DEPTH));
  assign ram_wr_addr = (op_q == OP_RAM_WR) ? idx_q : ptr_q[IDX_W-1:0];
  assign ram_rd_addr = (op_q == OP_RAM_RD) ? idx_q : ptr_q[IDX_W-1:0];

  rtc_clock_bank #(
    .CLK_REGS(CLK_REGS),
    .CIDX_W  (CIDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_fire),
    .wr_idx  (idx_q[CIDX_W-1:0]),
    .wr_data (byte_data),
    .stg_en  (stg_en),
    .stg_idx (ptr_q[CIDX_W-1:0]),
    .stg_data(byte_data),
    .commit  (burst_commit),
    .regs    (clk_regs)
  );

  rtc_scratch_ram #(
    .DEPTH(RAM_DEPTH),
    .AW   (IDX_W)
  ) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ram_wr_fire),
    .wr_addr(ram_wr_addr),
    .wr_data(byte_data),
    .rd_addr(ram_rd_addr),
    .rd_data(ram_rd_byte)
  );

  // Next transmit byte
  always_comb begin
    rd_next = 8'h00;
    if (active_q) begin
      case (op_q)
        OP_REG_RD:    rd_next = clk_regs[idx_q[CIDX_W-1:0]];
        OP_STAT_RD:   rd_next = status_byte(xtal_fail_i, data_valid_i, batt_low_i, alarm_i);
        OP_CBURST_RD: if (int'(ptr_q) < CLK_REGS) rd_next = clk_regs[ptr_q[CIDX_W-1:0]];
        OP_RAM_RD:    rd_next = ram_rd_byte;
        OP_RBURST_RD: if (int'(ptr_q) < RAM_DEPTH) rd_next = ram_rd_byte;
        default:      rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (rd_req) begin
      rd_data <= rd_next;
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= OP_NONE;
      idx_q    <= '0;
      ptr_q    <= '0;
      wp_lat_q <= 1'b0;
    end else if (xfer_end) begin
      active_q <= 1'b0;
      op_q     <= OP_NONE;
      ptr_q    <= '0;
    end else if (cmd_accept) begin
      active_q <= 1'b1;
      op_q     <= dec_op;
      idx_q    <= dec_idx;
      ptr_q    <= '0;
      wp_lat_q <= wp_now;
    end else if (ptr_step) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

endmodule

// File: rtl/rtc_cmd_access_chk.sv
module rtc_cmd_access_chk #(
  parameter int TIME_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              active,
  input logic              rd_is_status,
  input logic              wp_now,
  input logic              ram_wr_fire,
  input logic              burst_commit,
  input logic [7:0]        rd_data,
  input logic [TIME_W-1:0] time_regs
);

  // R3: protect blocks every RAM write
  a_r3_ram_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wp_now |-> !ram_wr_fire);

  // R3: protect freezes the timekeeping registers
  a_r3_time_regs_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wp_now |=> $stable(time_regs));

  // R5: a clock burst never commits while protect is set
  a_r5_no_commit_protected: assert property (@(posedge clk) disable iff (!rst_n)
    burst_commit |-> !wp_now);

  // R10: low status nibble is zero
  a_r10_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_is_status |=> rd_data[3:0] == 4'h0);

  // R1 / R11: no open command reads zero
  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !active |=> rd_data == 8'h00);

  // R12: read data holds without a request
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));

endmodule

bind rtc_cmd_access rtc_cmd_access_chk #(.TIME_W(8 * NUM_TIME_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .active      (active_q),
  .rd_is_status(rd_is_status),
  .wp_now      (wp_now),
  .ram_wr_fire (ram_wr_fire),
  .burst_commit(burst_commit),
  .rd_data     (rd_data),
  .time_regs   (time_regs_flat)
);

// File: tb/test_rtc_cmd_access.sv
`timescale 1ns/1ps
module test_rtc_cmd_access;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       xfer_end = 1'b0;
  logic       rd_req = 1'b0;
  logic       xtal_fail_i = 1'b0, data_valid_i = 1'b0, batt_low_i = 1'b0, alarm_i = 1'b0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rtc_cmd_access i_rtc_cmd_access (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .xfer_end(xfer_end), .rd_req(rd_req), .xtal_fail_i(xtal_fail_i),
    .data_valid_i(data_valid_i), .batt_low_i(batt_low_i), .alarm_i(alarm_i),
    .rd_data(rd_data)
  );

  // {write cmd, write data, read cmd, expected}
  localparam logic [31:0] VEC [6] = '{
    {8'h02, 8'h59, 8'h03, 8'h59},   // R2 register 0
    {8'h0C, 8'h12, 8'h0D, 8'h12},   // R2 register 5
    {8'h3E, 8'hA5, 8'h3F, 8'hA5},   // R7 RAM byte 0
    {8'hFC, 8'h5A, 8'hFD, 8'h5A},   // R7 RAM byte 95
    {8'h50, 8'h33, 8'h51, 8'h33},   // R7 RAM byte 9
    {8'h20, 8'h77, 8'h21, 8'h00}    // R11 undefined command
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic end_xfer();
    @(negedge clk); xfer_end = 1'b1;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    v = rd_data;
  endtask

  task automatic write1(input logic [7:0] cmd, input logic [7:0] d);
    send_byte(cmd); send_byte(d); end_xfer();
  endtask

  task automatic read1(input logic [7:0] cmd, output logic [7:0] v);
    send_byte(cmd); read_byte(v); end_xfer();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: read with no command open after reset
    read_byte(v);  check("R1 idle read after reset", v, 8'h00);
    end_xfer();

    // Vector table: single writes then reads
    for (int k = 0; k < 6; k++) begin
      write1(VEC[k][31:24], VEC[k][23:16]);
      read1(VEC[k][15:8], v);
      check($sformatf("R2/R7/R11 vector %0d", k), v, VEC[k][7:0]);
    end

    // R2: only the first data byte of a single write lands
    send_byte(8'h02); send_byte(8'h44); send_byte(8'h55); end_xfer();
    read1(8'h03, v); check("R2 first data byte only", v, 8'h44);

    // R11: write to unused 12h is ignored, register 0 intact
    write1(8'h12, 8'hEE);
    read1(8'h03, v); check("R11 unused write ignored", v, 8'h44);

    // R10: status byte
    xtal_fail_i = 1; data_valid_i = 0; batt_low_i = 1; alarm_i = 1;
    read1(8'h13, v); check("R10 status B0", v, 8'hB0);
    xtal_fail_i = 0; data_valid_i = 1; batt_low_i = 0; alarm_i = 0;
    read1(8'h13, v); check("R10 status 40", v, 8'h40);

    // R4: full clock burst write, R6: burst read plus overrun
    send_byte(8'h00);
    for (int i = 0; i < 8; i++) send_byte(8'h10 + 8'(i));
    end_xfer();
    send_byte(8'h01);
    for (int i = 0; i < 8; i++) begin
      read_byte(v); check($sformatf("R6 burst read reg %0d", i), v, 8'h10 + 8'(i));
    end
    read_byte(v); check("R6 burst read past end", v, 8'h00);
    end_xfer();

    // R12: rd_data holds between requests
    send_byte(8'h05); read_byte(held);
    repeat (4) @(negedge clk);
    check("R12 rd_data holds", rd_data, held);
    check("R12 value of reg 1", held, 8'h11);
    end_xfer();

    // R4: partial clock burst changes nothing
    send_byte(8'h00); send_byte(8'h21); send_byte(8'h22); send_byte(8'h23); end_xfer();
    read1(8'h03, v); check("R4 partial burst reg 0", v, 8'h10);
    read1(8'h11, v); check("R4 partial burst control", v, 8'h17);

    // R3: protect on
    write1(8'h10, 8'h80);
    read1(8'h11, v); check("R3 control writable", v, 8'h80);
    write1(8'h02, 8'h99);
    read1(8'h03, v); check("R3 register write blocked", v, 8'h10);
    write1(8'h3E, 8'h11);
    read1(8'h3F, v); check("R3 RAM write blocked", v, 8'hA5);

    // R5: burst write with protect set touches nothing
    send_byte(8'h00);
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    end_xfer();
    read1(8'h11, v); check("R5 control unchanged", v, 8'h80);
    read1(8'h03, v); check("R5 reg 0 unchanged", v, 8'h10);

    // R3: clear protect through control
    write1(8'h10, 8'h00);
    read1(8'h11, v); check("R3 protect cleared", v, 8'h00);
    write1(8'h02, 8'h99);
    read1(8'h03, v); check("R3 write after clear", v, 8'h99);

    // R8: partial RAM burst keeps delivered bytes
    send_byte(8'hFE);
    for (int i = 0; i < 5; i++) send_byte(8'(i) ^ 8'h3C);
    end_xfer();
    read1(8'h3F, v); check("R8 partial byte 0", v, 8'h3C);
    read1(8'h47, v); check("R8 partial byte 4", v, 8'h38);
    read1(8'h49, v); check("R8 byte 5 untouched", v, 8'h00);

    // R8: full burst with two extra bytes, R9: burst read
    send_byte(8'hFE);
    for (int i = 0; i < 98; i++) send_byte(8'(i + 1));
    end_xfer();
    read1(8'hFD, v); check("R8 byte 95 not overrun", v, 8'h60);
    read1(8'h3F, v); check("R8 byte 0 no wrap", v, 8'h01);
    send_byte(8'hFF);
    for (int i = 0; i < 96; i++) begin
      read_byte(v); check($sformatf("R9 burst read byte %0d", i), v, 8'(i + 1));
    end
    read_byte(v); check("R9 burst read past end", v, 8'h00);
    end_xfer();

    // R1: new command after end strobe works
    read1(8'h1D, v); check("R1 new command after end", v, 8'h00);
    read1(8'h03, v); check("R1 reg 0 after end", v, 8'h99);

    finish_up();
  end

endmodule